// File: doc/BRIEF.md
# Serial Readback and Cascade Output Stage

This block drives the serial data output of a serial-input DAC. It samples the serial clock, the active-low frame select, the active-low readback request and the serial data input with a fast system clock, and acts on every falling edge of the serial clock. In normal operation it is a 16-stage delay line. Each word written into the device comes out on the serial output one word later, so the next device in a chain can take it.

When the readback request goes low, the next serial-clock falling edge copies the DAC register into the shift register. The code is placed behind two leading zeros, and the 16-bit word is then shifted out MSB first. The output behaves as an open drain: the block only asks for the line to be pulled low or released, and an external pull-up supplies the high level. A parameter selects a 14-bit code or a 12-bit code.

Top module: `sdo_chain_readback`

## Requirements
- R1: While `sync_ni` is low and no readback is running, each SCLK falling edge shifts `sdin_i` into a 16-bit register, MSB first. A bit taken at falling edge k reaches register bit 15 at edge k+15, so a downstream device samples it at edge k+16.
- R2: The output changes only as a result of an SCLK falling edge. It settles 3 system clocks after the pin edge and holds while SCLK is high.
- R3: `sdo_pd_o` = 1 requests a pull-low (register bit 15 is 0), and 0 releases the line (bit 15 is 1). Reset fills the register with ones, so the line is released.
- R4: The first SCLK falling edge after `rben_ni` falls loads the readback word, with bits 15:14 = 0. With CODE_W=14 the code fills bits 13:0. With CODE_W=12 it fills bits 13:2, and bits 1:0 are 0.
- R5: After a load, the next 15 falling edges shift out the rest of the word whatever the levels of `sync_ni` and `rben_ni`. The bit shifted in is `sdin_i` when `sync_ni` is low and 0 otherwise.
- R6: One fall of `rben_ni` causes exactly one load. Holding it low gives no further loads, and a change of `dac_code_i` after the load does not alter the word being shifted out.
- R7: If a load and a frame shift fall on the same edge, the load wins. A fall of `rben_ni` that is seen together with an SCLK falling edge loads on that same edge.
- R8: With `sync_ni` high and no readback pending or running, SCLK falling edges leave the register, and so the output, unchanged.
- R9: All four serial inputs pass through two synchronizer flops with matched delay. `rst_ni` is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in |
| sync_ni | input | 1 | Frame select, active low |
| rben_ni | input | 1 | Readback request, active low |
| dac_code_i | input | CODE_W | Current DAC register contents |
| sdo_pd_o | output | 1 | 1 = pull serial output low, 0 = release |

## Verification
The parallel load and the pass-through shift can fall on the same SCLK edge. This happens when a readback request arrives inside a write frame, or when the readback request falls at the same instant as SCLK. The bench provokes both cases: it drops `rben_ni` with `sync_ni` low, and it drops `rben_ni` in the same statement that lowers SCLK. The bench then checks each later output bit against its own model, which loads the word and ignores the shift on that edge.

// File: rtl/sdo_rb_pkg.sv
package sdo_rb_pkg;
  localparam int WORD_W = 16;
  localparam int HEAD_W = 2;
  localparam int SYNC_STAGES = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sdo_sync.sv
module sdo_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sdo_edge.sv
module sdo_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic rben_ns_i,
  output logic sclk_fall_o,
  output logic rben_fall_o
);
  logic sclk_prev_q, rben_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      rben_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      rben_prev_q <= rben_ns_i;
    end
  end

  assign sclk_fall_o = sclk_prev_q & ~sclk_s_i;
  assign rben_fall_o = rben_prev_q & ~rben_ns_i;

  // R2: one strobe per pin edge
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |=> !sclk_fall_o);
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
  import sdo_rb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_fall_i,
  input  logic  rben_fall_i,
  input  logic  sync_ni,
  input  logic  sdin_i,
  input  word_t word_i,
  output logic  msb_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] RB_LAST = CNT_W'(WORD_W - 1);

  word_t            sr_q;
  logic [CNT_W-1:0] rb_cnt_q;
  logic             armed_q;
  logic             load, shift, rb_busy;

  assign rb_busy = (rb_cnt_q != '0);
  assign load    = sclk_fall_i & (armed_q | rben_fall_i);
  assign shift   = sclk_fall_i & ~load & (~sync_ni | rb_busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '1;
      rb_cnt_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (load) begin
        sr_q     <= word_i;
        rb_cnt_q <= RB_LAST;
        armed_q  <= 1'b0;
      end else begin
        if (rben_fall_i) armed_q <= 1'b1;
        if (shift) begin
          sr_q <= {sr_q[WORD_W-2:0], sdin_i & ~sync_ni};
          if (rb_busy) rb_cnt_q <= rb_cnt_q - 1'b1;
        end
      end
    end
  end

  assign msb_o = sr_q[WORD_W-1];

  a_r4_head_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> sr_q[WORD_W-1 -: HEAD_W] == '0);
  a_r5_rb_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> rb_cnt_q == RB_LAST);
  a_r6_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !armed_q);
  a_r7_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && !sync_ni && (armed_q || rben_fall_i)) |=> sr_q == $past(word_i));
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && sync_ni && !rb_busy && !armed_q && !rben_fall_i) |=> $stable(sr_q));
endmodule

// File: rtl/sdo_chain_readback.sv
module sdo_chain_readback
  import sdo_rb_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              sync_ni,
  input  logic              rben_ni,
  input  logic [CODE_W-1:0] dac_code_i,
  output logic              sdo_pd_o
);
  localparam int PAD_LO = WORD_W - HEAD_W - CODE_W;

  logic [3:0] raw, syn;
  logic       sclk_fall, rben_fall, msb;
  word_t      rb_word;

  assign raw = {sclk_i, sync_ni, rben_ni, sdin_i};

  sdo_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sdo_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (syn[3]),
    .rben_ns_i  (syn[1]),
    .sclk_fall_o(sclk_fall),
    .rben_fall_o(rben_fall)
  );

  if (PAD_LO > 0) begin : g_pad
    assign rb_word = {{HEAD_W{1'b0}}, dac_code_i, {PAD_LO{1'b0}}};
  end else begin : g_full
    assign rb_word = {{HEAD_W{1'b0}}, dac_code_i};
  end

  sdo_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_fall_i(sclk_fall),
    .rben_fall_i(rben_fall),
    .sync_ni    (syn[2]),
    .sdin_i     (syn[0]),
    .word_i     (rb_word),
    .msb_o      (msb)
  );

  // open drain: only pull low for a zero bit
  assign sdo_pd_o = ~msb;

  a_r2_moves_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_pd_o) |-> $past(sclk_fall));
endmodule

// File: tb/tb_sdo_chain_readback.sv
module tb_sdo_chain_readback;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, sync_n = 1'b1, rben_n = 1'b1;
  logic [13:0] code = '0;
  logic pd14, pd12;
  int total = 0, bad = 0;
  bit done = 0;

  always #4ns clk = ~clk;

  sdo_chain_readback #(.CODE_W(14)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .sync_ni(sync_n), .rben_ni(rben_n), .dac_code_i(code), .sdo_pd_o(pd14));

  sdo_chain_readback #(.CODE_W(12)) dut12 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin),
    .sync_ni(sync_n), .rben_ni(rben_n), .dac_code_i(code[11:0]), .sdo_pd_o(pd12));

  logic [15:0] m14 = 16'hFFFF, m12 = 16'hFFFF;
  int left = 0;
  bit armed = 0;

  function automatic logic [15:0] word14(logic [13:0] c);
    return {2'b00, c};
  endfunction
  function automatic logic [15:0] word12(logic [11:0] c);
    return {2'b00, c, 2'b00};
  endfunction

  task automatic chk(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  // one SCLK cycle; optionally drop rben together with the falling edge
  task automatic pulse(input logic din, input string tag, input bit rb_with_edge = 0);
    sdin = din;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", pd14, ~m14[15]);
    sclk = 1'b0;
    if (rb_with_edge) begin rben_n = 1'b0; armed = 1; end
    if (armed) begin
      armed = 0;
      m14 = word14(code);
      m12 = word12(code[11:0]);
      left = 15;
    end else if (!sync_n || left > 0) begin
      m14 = {m14[14:0], din & ~sync_n};
      m12 = {m12[14:0], din & ~sync_n};
      if (left > 0) left--;
    end
    repeat (5) @(negedge clk);
    chk(tag, pd14, ~m14[15]);
    chk(tag, pd12, ~m12[15]);
  endtask

  task automatic rb_drop();
    rben_n = 1'b0;
    armed = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rb_release();
    rben_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R9 reset state, R3 released line
    chk("R9", pd14, 1'b0);
    chk("R3", pd12, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", pd14, 1'b0);

    // R1 pass-through, random bits
    sync_n = 1'b0;
    for (int i = 0; i < 40; i++) pulse(1'($urandom), "R1");
    sync_n = 1'b1;
    // R8 idle edges leave contents
    for (int i = 0; i < 6; i++) pulse(1'($urandom), "R8");
    sync_n = 1'b0;
    for (int i = 0; i < 16; i++) pulse(1'($urandom), "R1");
    sync_n = 1'b1;

    // R4/R5 readback framed by rben, directed and random codes
    for (int k = 0; k < 6; k++) begin
      code = (k == 0) ? 14'h3FFF : (k == 1) ? 14'h0000 : 14'($urandom);
      rb_drop();
      for (int i = 0; i < 16; i++) pulse(1'($urandom), "R4");
      rb_release();
    end

    // R5 early release after load, then R8 idle
    code = 14'h2A5C;
    rb_drop();
    pulse(1'b1, "R4");
    rb_release();
    for (int i = 0; i < 15; i++) pulse(1'($urandom), "R5");
    for (int i = 0; i < 4; i++) pulse(1'($urandom), "R8");

    // R6 hold low, change code after load, no reload
    code = 14'h1357;
    rb_drop();
    pulse(1'b0, "R6");
    code = 14'h3C3C;
    for (int i = 0; i < 15; i++) pulse(1'($urandom), "R6");
    for (int i = 0; i < 4; i++) pulse(1'b1, "R6");
    rb_release();

    // R7 load over an active write frame
    sync_n = 1'b0;
    for (int i = 0; i < 5; i++) pulse(1'($urandom), "R1");
    code = 14'h0F0F;
    rb_drop();
    pulse(1'b1, "R7");
    rb_release();
    for (int i = 0; i < 20; i++) pulse(1'($urandom), "R5");
    sync_n = 1'b1;

    // R7 rben fall together with SCLK fall
    code = 14'h25B1;
    pulse(1'b0, "R7", 1'b1);
    for (int i = 0; i < 15; i++) pulse(1'b0, "R7");
    rb_release();
    for (int i = 0; i < 3; i++) pulse(1'b1, "R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule